// File: doc/BRIEF.md
# ADC Conversion Sequencer with Result Interlock

This block is the digital control and register front end of a 10-bit successive-approximation converter. A CPU-side register port writes a control byte that carries a 5-bit channel code, a repeat bit and a resolution bit. Each control write starts a conversion on the chosen channel, unless the code is all ones. The converter side sees a one-cycle start strobe and the selected channel. It answers with a completion pulse and the 10-bit sample.

Results land in a high/low register pair. In 10-bit resolution, reading the high byte locks the pair until the low byte is read. Completions that arrive while the pair is locked are dropped, so the two halves a program reads always come from the same sample. In 8-bit resolution the low byte alone carries the sample and the pair has no lock.

Channel code 31 shuts the converter down and isolates the pad. An idle output tells the power logic when no conversion is in flight.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the control register (address 0) reads 8'h1F, both result registers read 0, `idle` and `pad_isolate` are 1, and `conv_start` is 0.
- R2: A write to address 0 is decoded as follows. Bits 4:0 are the channel, bit 5 is repeat, bit 6 is 8-bit resolution, and bit 7 is read-only. If the channel is not 31, `conv_start` is high for the one cycle after the write, `conv_chan` shows the channel, and `idle` is 0.
- R3: With repeat clear, the first completion makes the block idle, and no further start follows.
- R4: With repeat set, every accepted completion raises `conv_start` in the next cycle.
- R5: Writing channel 31 gives no start, sets `idle` and `pad_isolate`, ends repeat mode, and makes later completion pulses have no effect on the results.
- R6: In 10-bit resolution, a transfer puts sample bits 9:8 in bits 1:0 of address 1, with bits 7:2 reading 0. Sample bits 7:0 go to address 2.
- R7: In 8-bit resolution, address 2 receives sample bits 9:2 and address 1 reads 0. Reading address 1 does not block later transfers.
- R8: In 10-bit resolution, a read of address 1 blocks transfers until address 2 is read. Completions during the block are discarded.
- R9: Bit 7 of address 0 is set when a result transfers in and is cleared by any write to address 0.
- R10: A control write aborts a running conversion. It releases any lock and ignores a completion pulse that arrives in the same cycle.
- R11: A completion in the same cycle as a 10-bit read of address 1 is discarded, and the lock is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address (0 control, 1 high, 2 low) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| conv_start | output | 1 | One-cycle conversion start |
| conv_chan | output | 5 | Selected channel |
| conv_done | input | 1 | Conversion complete pulse |
| conv_data | input | 10 | Converted sample, valid with `conv_done` |
| idle | output | 1 | No conversion in flight (low-power) |
| pad_isolate | output | 1 | Converter off and input isolated |

## Verification
The key coincidence is a completion pulse arriving in the very edge where software reads the high byte in 10-bit mode. The bench raises `conv_done` and a read of address 1 together. It expects the read to return the old high byte, the sample to be dropped, and the old low byte to follow. A second coincidence puts a control write and a completion in the same edge. The bench expects the pulse to be ignored: the done flag stays clear and the old low byte survives.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES_W = 10,
  parameter int CH_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic             idle,
  output logic             pad_isolate
);
  localparam int HI_W = RES_W - 8;
  localparam logic [CH_W-1:0] CH_OFF = '1;

  logic [CH_W-1:0] chan;
  logic            rep, mode8, coco, busy, lock;
  logic [HI_W-1:0] res_hi;
  logic [7:0]      res_lo;

  wire ctrl_wr = wr_en && addr == 2'd0;
  wire hi_rd   = rd_en && addr == 2'd1 && !mode8;
  wire lo_rd   = rd_en && addr == 2'd2;
  wire accept  = conv_done && busy && !ctrl_wr;
  wire xfer    = accept && !lock && !hi_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan <= CH_OFF; rep <= 1'b0; mode8 <= 1'b0; coco <= 1'b0;
      busy <= 1'b0; lock <= 1'b0; conv_start <= 1'b0;
      res_hi <= '0; res_lo <= '0;
    end else if (ctrl_wr) begin
      chan       <= wdata[CH_W-1:0];
      rep        <= wdata[5];
      mode8      <= wdata[6];
      coco       <= 1'b0;
      lock       <= 1'b0;
      busy       <= wdata[CH_W-1:0] != CH_OFF;
      conv_start <= wdata[CH_W-1:0] != CH_OFF;
    end else begin
      conv_start <= accept && rep;
      if (accept && !rep) busy <= 1'b0;
      if (xfer) begin
        coco <= 1'b1;
        if (mode8) begin
          res_lo <= conv_data[RES_W-1 -: 8];
          res_hi <= '0;
        end else begin
          res_lo <= conv_data[7:0];
          res_hi <= conv_data[RES_W-1:8];
        end
      end
      if (lo_rd)      lock <= 1'b0;
      else if (hi_rd) lock <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {coco, mode8, rep, chan};
      2'd1:    rdata = {{(8-HI_W){1'b0}}, res_hi};
      2'd2:    rdata = res_lo;
      default: rdata = 8'h00;
    endcase
  end

  assign conv_chan   = chan;
  assign idle        = !busy;
  assign pad_isolate = chan == CH_OFF;

  a_r2_start_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[CH_W-1:0] != CH_OFF) |=> (conv_start && !idle));
  a_r5_off_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[CH_W-1:0] == CH_OFF) |=> (!conv_start && idle && pad_isolate));
  a_r3_single_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !idle && !rep && !ctrl_wr) |=> (idle && !conv_start));
  a_r4_repeat_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !idle && rep && !ctrl_wr) |=> conv_start);
  a_r8_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !lo_rd && !ctrl_wr) |=> ($stable(res_lo) && $stable(res_hi)));
  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !rdata[7] || addr != 2'd0);
  a_r7_no_lock_8bit: assert property (@(posedge clk) disable iff (!rst_n)
    mode8 |-> !lock);
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, conv_done = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [9:0] conv_data = 0;
  logic [7:0] rdata;
  logic conv_start, idle, pad_isolate;
  logic [4:0] conv_chan;

  int n_chk = 0, n_bad = 0;
  bit  finished = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  adc_seq_ctrl dut (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
    .conv_start, .conv_chan, .conv_done, .conv_data, .idle, .pad_isolate);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rd_en && exp_q.size() > 0) begin
    logic [7:0] e; string t;
    e = exp_q.pop_front(); t = tag_q.pop_front();
    n_chk++;
    if (rdata !== e) begin
      n_bad++;
      $display("FAIL %s: read addr %0d got %h expected %h", t, addr, rdata, e);
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string t);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  task automatic wr(input logic [7:0] d, input bit with_done = 0, input logic [9:0] s = 0);
    wr_en = 1; addr = 0; wdata = d; conv_done = with_done; conv_data = s;
    step(); wr_en = 0; conv_done = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t,
                    input bit with_done = 0, input logic [9:0] s = 0);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1; addr = a; conv_done = with_done; conv_data = s;
    step(); rd_en = 0; conv_done = 0;
  endtask

  task automatic done(input logic [9:0] s);
    conv_done = 1; conv_data = s; step(); conv_done = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*2) rst_n = 1;
    step();
    // R1 reset state
    rd(0, 8'h1F, "R1 ctrl");
    rd(1, 8'h00, "R1 hi"); rd(2, 8'h00, "R1 lo");
    chk(idle, 1, "R1 idle"); chk(pad_isolate, 1, "R1 iso"); chk(conv_start, 0, "R1 start");
    // R2 / R3 / R6 single 10-bit
    wr(8'h03);
    chk(conv_start, 1, "R2 start"); chk(conv_chan, 3, "R2 chan");
    chk(idle, 0, "R2 busy"); chk(pad_isolate, 0, "R2 iso");
    step(); chk(conv_start, 0, "R2 pulse width");
    done(10'h2A5);
    chk(idle, 1, "R3 idle"); chk(conv_start, 0, "R3 no restart");
    rd(0, 8'h83, "R9 flag set");
    rd(1, 8'h02, "R6 hi"); rd(2, 8'hA5, "R6 lo");
    step(); step(); chk(conv_start, 0, "R3 stays stopped");
    // R4 / R8 repeat with interlock
    wr(8'h25);
    rd(0, 8'h25, "R9 flag cleared");
    done(10'h155); chk(conv_start, 1, "R4 restart");
    rd(1, 8'h01, "R8 hi locks");
    done(10'h3C3); chk(conv_start, 1, "R4 restart while locked");
    rd(1, 8'h01, "R8 hi held"); rd(2, 8'h55, "R8 lo held");
    done(10'h2F0);
    rd(1, 8'h02, "R8 new hi"); rd(2, 8'hF0, "R8 new lo");
    // R5 off
    wr(8'h1F);
    chk(conv_start, 0, "R5 no start"); chk(idle, 1, "R5 idle"); chk(pad_isolate, 1, "R5 iso");
    done(10'h111);
    rd(2, 8'hF0, "R5 stray done ignored");
    step(); chk(conv_start, 0, "R5 repeat ended");
    // R7 8-bit
    wr(8'h41); done(10'h3FD);
    rd(1, 8'h00, "R7 hi zero"); rd(2, 8'hFF, "R7 lo upper bits");
    wr(8'h61); done(10'h204);
    rd(1, 8'h00, "R7 hi no lock");
    done(10'h0C8);
    rd(2, 8'h32, "R7 no interlock");
    // R10 abort
    wr(8'h22); done(10'h1AB);
    rd(1, 8'h01, "R10 lock set");
    wr(8'h02, 1, 10'h3FF);
    chk(conv_start, 1, "R10 restart");
    rd(0, 8'h02, "R10 done ignored");
    rd(2, 8'hAB, "R10 lo kept");
    done(10'h155);
    rd(2, 8'h55, "R10 lock released");
    chk(idle, 1, "R10 single idle");
    // R11 coincident hi read and completion
    wr(8'h24); done(10'h0AA);
    rd(1, 8'h00, "R11 hi old", 1, 10'h3EE);
    chk(conv_start, 1, "R11 repeat continues");
    rd(2, 8'hAA, "R11 sample dropped");
    rd(0, 8'hA4, "R11 flag");
    wr(8'h1F);
    step();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule